// File: doc/BRIEF.md
# Two-Word Burst SRAM Command Scheduler

This block sits between a user request queue and a two-word-burst, double-data-rate SRAM that has separate data-in and data-out buses. Each user request moves one 36-bit word, which the memory handles as two 18-bit beats. The user side is a valid/ready handshake that carries a write flag, a word address, write data with a 4-bit byte-lane enable and a tag. The block turns each accepted request into a command on the memory pins one cycle later. It drives the active-low load strobe, a read/write flag (high means read) and the address.

For writes, the block drives both data beats and their lane enables in the cycle after the command. The physical layer sends the rise-lane beat on the next main-clock rise and the fall-lane beat on the half-cycle edge that follows. For reads, the physical layer returns the data already split into a rise lane and a fall lane for each main-clock cycle. The block picks its capture point from the latency mode: 1 cycle when the device's delay-locked loop is off, 1.5 cycles when it is on. It joins the two beats into one word and returns it with the request's tag and a one-cycle valid pulse, in issue order.

When a write follows a read, the block inserts one or two idle cycles, chosen by a configuration input, so the data buses can turn around. Reads after reads, writes after writes, and reads after writes issue on consecutive cycles.

Top module: `burst_sram_sched`

## Requirements
- R1: While reset is held and right after it is released, the load strobe is high, no response is valid, both lane-enable pairs are zero, and requests are ready.
- R2: A request accepted in cycle t (valid and ready both high) is on the pins during cycle t+1. The load strobe is low, the read/write flag is high for a read and low for a write, and the address equals the request address.
- R3: Between a read command on the pins and a following write command, at least one idle pin cycle appears. With `cfg_two_gap` high, at least two appear. Ready is low for a waiting write for exactly as many cycles as are needed to make up that gap, counting idle cycles the user already left.
- R4: A series of reads, or a series of writes, presented on consecutive cycles is accepted one per cycle, with no ready-low cycle.
- R5: In any cycle after one with no accepted request, the load strobe is high.
- R6: For a write accepted in cycle t, during cycle t+2 the rise lane carries write data bits 17:0 with enables `req_be[1:0]`, and the fall lane carries bits 35:18 with enables `req_be[3:2]`. Enable bit 0 of a pair covers beat bits 8:0 and bit 1 covers bits 17:9. In every other cycle all four enables are zero.
- R7: For a read on the pins during cycle c, the response valid pulse appears in cycle c+3 when `cfg_dll_on` is low and in cycle c+4 when it is high.
- R8: The response word holds the first-arriving beat in bits 17:0 and the second in bits 35:18. With the loop off, these are the rise and fall lanes of cycle c+2. With it on, they are the fall lane of c+2 and the rise lane of c+3. Against a linear-burst device, the word read from address a is {word at a XOR 1, word at a}.
- R9: Each accepted read produces exactly one response, responses come back in acceptance order, and each carries the tag given with its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dll_on | input | 1 | High selects 1.5-cycle read latency, low selects 1-cycle |
| cfg_two_gap | input | 1 | High inserts two idle cycles on a read-to-write change, low inserts one |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | High for write, low for read |
| req_addr | input | ADDR_W | Word address (bit 0 selects the first beat) |
| req_wdata | input | 36 | Write word: bits 17:0 first beat, 35:18 second beat |
| req_be | input | 4 | Lane enables: 1:0 first beat, 3:2 second beat |
| req_tag | input | TAG_W | Tag returned with a read response |
| rsp_valid | output | 1 | Read response valid, one cycle |
| rsp_data | output | 36 | Read word, first beat in bits 17:0 |
| rsp_tag | output | TAG_W | Tag of the answered read |
| mem_ld_n | output | 1 | Active-low load strobe |
| mem_rw | output | 1 | High read, low write |
| mem_addr | output | ADDR_W | Command address |
| mem_d_rise | output | 18 | Write beat for the main-clock rise |
| mem_d_fall | output | 18 | Write beat for the following half-cycle edge |
| mem_be_rise | output | 2 | Lane enables for the rise beat |
| mem_be_fall | output | 2 | Lane enables for the fall beat |
| mem_q_rise | input | 18 | Read beat captured on the rise of this cycle |
| mem_q_fall | input | 18 | Read beat captured on the fall of this cycle |

## Verification
The properties assume that `cfg_dll_on` and `cfg_two_gap` change only while reset is held. They also assume that the device answers every read on the lanes and in the cycles given for the selected mode. The stimulus sets both options during reset and sweeps all four combinations, one per reset. A burst memory model answers each read at the fixed offset for the selected mode, so the capture points are exercised with back-to-back and isolated reads. The write-to-read and read-to-write sequences leave zero to three user idle cycles, so the measured stall is compared against a gap that the user has partly or fully covered already.

// File: rtl/sram_sched_pkg.sv
package sram_sched_pkg;

    localparam int BEAT_W = 18;
    localparam int LANE_W = 9;
    localparam int LANES  = BEAT_W / LANE_W;
    localparam int WORD_W = 2 * BEAT_W;
    localparam int MASK_W = 2 * LANES;
    localparam int GAP_W  = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic             vld;
        beat_t            first;
        beat_t            second;
        logic [LANES-1:0] en_first;
        logic [LANES-1:0] en_second;
    } wr_burst_t;

    function automatic logic [GAP_W-1:0] gap_cycles(input logic two);
        return two ? GAP_W'(2) : GAP_W'(1);
    endfunction

    function automatic wr_burst_t make_burst(input logic [WORD_W-1:0] d,
                                             input logic [MASK_W-1:0] m);
        wr_burst_t b;
        b.vld       = 1'b1;
        b.first     = d[BEAT_W-1:0];
        b.second    = d[WORD_W-1:BEAT_W];
        b.en_first  = m[LANES-1:0];
        b.en_second = m[MASK_W-1:LANES];
        return b;
    endfunction

endpackage

// File: rtl/sched_turn_gap.sv
module sched_turn_gap
    import sram_sched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_two_gap,
    input  logic rd_taken,
    output logic wr_hold
);

    logic [GAP_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (rd_taken) begin
            left_q <= gap_cycles(cfg_two_gap);
        end else if (left_q != '0) begin
            left_q <= left_q - GAP_W'(1);
        end
    end

    assign wr_hold = (left_q != '0);

endmodule

// File: rtl/sched_wr_stage.sv
module sched_wr_stage
    import sram_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_taken,
    input  logic [WORD_W-1:0] wdata,
    input  logic [MASK_W-1:0] wmask,
    output beat_t             d_rise,
    output beat_t             d_fall,
    output logic [LANES-1:0]  en_rise,
    output logic [LANES-1:0]  en_fall
);

    wr_burst_t cmd_q;
    wr_burst_t lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            lane_q <= '0;
        end else begin
            cmd_q  <= wr_taken ? make_burst(wdata, wmask) : '0;
            lane_q <= cmd_q.vld ? cmd_q : '0;
        end
    end

    assign d_rise  = lane_q.first;
    assign d_fall  = lane_q.second;
    assign en_rise = lane_q.en_first;
    assign en_fall = lane_q.en_second;

endmodule

// File: rtl/sched_rd_capture.sv
module sched_rd_capture
    import sram_sched_pkg::*;
#(
    parameter int TAG_W = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dll_on,
    input  logic              issue_rd,
    input  logic [TAG_W-1:0]  issue_tag,
    input  beat_t             q_rise,
    input  beat_t             q_fall,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag
);

    localparam int DEPTH    = 3;
    localparam int SLOT_ONE = 1;
    localparam int SLOT_TWO = 2;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } slot_t;

    slot_t pipe [DEPTH];
    beat_t early_q;
    slot_t pick;
    logic [WORD_W-1:0] word;

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= '{vld: issue_rd, tag: issue_tag};
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[i] <= '0;
            else     pipe[i] <= pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            early_q <= '0;
        end else if (pipe[SLOT_ONE].vld) begin
            early_q <= q_fall;
        end
    end

    always_comb begin
        if (cfg_dll_on) begin
            pick = pipe[SLOT_TWO];
            word = {q_rise, early_q};
        end else begin
            pick = pipe[SLOT_ONE];
            word = {q_fall, q_rise};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_tag   <= '0;
        end else begin
            rsp_valid <= pick.vld;
            if (pick.vld) begin
                rsp_data <= word;
                rsp_tag  <= pick.tag;
            end
        end
    end

endmodule

// File: rtl/burst_sram_sched.sv
module burst_sram_sched
    import sram_sched_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int TAG_W  = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dll_on,
    input  logic              cfg_two_gap,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [MASK_W-1:0] req_be,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              mem_ld_n,
    output logic              mem_rw,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_d_rise,
    output logic [BEAT_W-1:0] mem_d_fall,
    output logic [LANES-1:0]  mem_be_rise,
    output logic [LANES-1:0]  mem_be_fall,
    input  logic [BEAT_W-1:0] mem_q_rise,
    input  logic [BEAT_W-1:0] mem_q_fall
);

    logic              wr_hold;
    logic              take;
    logic              take_rd;
    logic              take_wr;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]  tag_q;

    assign req_ready = !(req_write && wr_hold);
    assign take      = req_valid && req_ready;
    assign take_rd   = take && !req_write;
    assign take_wr   = take && req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            addr_q <= '0;
            tag_q  <= '0;
        end else begin
            op_q <= take ? (req_write ? OP_WRITE : OP_READ) : OP_IDLE;
            if (take) begin
                addr_q <= req_addr;
                tag_q  <= req_tag;
            end
        end
    end

    assign mem_ld_n = (op_q == OP_IDLE);
    assign mem_rw   = (op_q != OP_WRITE);
    assign mem_addr = addr_q;

    sched_turn_gap u_gap (
        .clk         (clk),
        .rst         (rst),
        .cfg_two_gap (cfg_two_gap),
        .rd_taken    (take_rd),
        .wr_hold     (wr_hold)
    );

    sched_wr_stage u_wr (
        .clk      (clk),
        .rst      (rst),
        .wr_taken (take_wr),
        .wdata    (req_wdata),
        .wmask    (req_be),
        .d_rise   (mem_d_rise),
        .d_fall   (mem_d_fall),
        .en_rise  (mem_be_rise),
        .en_fall  (mem_be_fall)
    );

    sched_rd_capture #(.TAG_W(TAG_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .cfg_dll_on (cfg_dll_on),
        .issue_rd   (op_q == OP_READ),
        .issue_tag  (tag_q),
        .q_rise     (mem_q_rise),
        .q_fall     (mem_q_fall),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .rsp_tag    (rsp_tag)
    );

endmodule

// File: rtl/burst_sram_sched_chk.sv
module burst_sram_sched_chk
    import sram_sched_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int TAG_W  = 4
)(
    input logic              clk,
    input logic              rst,
    input logic              cfg_dll_on,
    input logic              cfg_two_gap,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              mem_ld_n,
    input logic              mem_rw,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_be_rise,
    input logic [LANES-1:0]  mem_be_fall
);

    logic pin_rd;
    logic pin_wr;
    assign pin_rd = !mem_ld_n && mem_rw;
    assign pin_wr = !mem_ld_n && !mem_rw;

    AST_ACCEPT_TO_PINS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!mem_ld_n && (mem_rw == !$past(req_write)) && (mem_addr == $past(req_addr)))); // R2

    AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> mem_ld_n); // R5

    AST_ONE_NOP: assert property (@(posedge clk) disable iff (rst)
        pin_wr |-> !$past(pin_rd)); // R3

    AST_TWO_NOP: assert property (@(posedge clk) disable iff (rst)
        (cfg_two_gap && pin_wr) |-> !$past(pin_rd, 2)); // R3

    AST_BE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|{mem_be_rise, mem_be_fall}) |-> $past(pin_wr)); // R6

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (cfg_dll_on ? $past(pin_rd, 4) : $past(pin_rd, 3))); // R7

endmodule

bind burst_sram_sched burst_sram_sched_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/burst_sram_sched_test.sv
module burst_sram_sched_test;

    localparam int PERIOD = 10;
    localparam int AW     = 4;
    localparam int TW     = 4;
    localparam int NWORDS = 1 << AW;
    localparam logic [17:0] IDLE_PAT = 18'h15555;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_dll_on = 1'b0;
    logic            cfg_two_gap = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [35:0]     req_wdata = '0;
    logic [3:0]      req_be = '0;
    logic [TW-1:0]   req_tag = '0;
    logic            rsp_valid;
    logic [35:0]     rsp_data;
    logic [TW-1:0]   rsp_tag;
    logic            mem_ld_n;
    logic            mem_rw;
    logic [AW-1:0]   mem_addr;
    logic [17:0]     mem_d_rise;
    logic [17:0]     mem_d_fall;
    logic [1:0]      mem_be_rise;
    logic [1:0]      mem_be_fall;
    logic [17:0]     mem_q_rise;
    logic [17:0]     mem_q_fall;

    burst_sram_sched #(.ADDR_W(AW), .TAG_W(TW)) uut (
        .clk(clk), .rst(rst), .cfg_dll_on(cfg_dll_on), .cfg_two_gap(cfg_two_gap),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
        .mem_ld_n(mem_ld_n), .mem_rw(mem_rw), .mem_addr(mem_addr),
        .mem_d_rise(mem_d_rise), .mem_d_fall(mem_d_fall),
        .mem_be_rise(mem_be_rise), .mem_be_fall(mem_be_fall),
        .mem_q_rise(mem_q_rise), .mem_q_fall(mem_q_fall)
    );

    always #(PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    // ---------------- burst memory model ----------------
    logic [17:0] mdl [NWORDS];
    logic [17:0] sr [3];
    logic [17:0] sf [3];
    logic        wpend;
    logic [AW-1:0] wa;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) mdl[i] = '0;
            for (int i = 0; i < 3; i++) begin sr[i] = IDLE_PAT; sf[i] = IDLE_PAT; end
            wpend = 1'b0;
            wa = '0;
            mem_q_rise <= IDLE_PAT;
            mem_q_fall <= IDLE_PAT;
        end else begin
            if (wpend) begin
                for (int ln = 0; ln < 2; ln++) begin
                    if (mem_be_rise[ln]) mdl[wa][ln*9 +: 9] = mem_d_rise[ln*9 +: 9];
                    if (mem_be_fall[ln]) mdl[wa ^ AW'(1)][ln*9 +: 9] = mem_d_fall[ln*9 +: 9];
                end
            end
            wpend = !mem_ld_n && !mem_rw;
            wa = mem_addr;
            sr[0] = sr[1]; sr[1] = sr[2]; sr[2] = IDLE_PAT;
            sf[0] = sf[1]; sf[1] = sf[2]; sf[2] = IDLE_PAT;
            if (!mem_ld_n && mem_rw) begin
                if (!cfg_dll_on) begin
                    sr[1] = mdl[mem_addr];
                    sf[1] = mdl[mem_addr ^ AW'(1)];
                end else begin
                    sf[1] = mdl[mem_addr];
                    sr[2] = mdl[mem_addr ^ AW'(1)];
                end
            end
            mem_q_rise <= sr[0];
            mem_q_fall <= sf[0];
        end
    end

    // ---------------- expectations ----------------
    typedef struct { int due; bit wr; logic [AW-1:0] addr; } pin_exp_t;
    typedef struct { int due; logic [35:0] data; logic [3:0] be; } wr_exp_t;
    typedef struct { int due; logic [TW-1:0] tag; logic [35:0] data; } rd_exp_t;

    pin_exp_t pq[$];
    wr_exp_t  wq[$];
    rd_exp_t  rq[$];
    logic [17:0] mir [NWORDS];
    int last_rd = -100;
    logic [TW-1:0] tag_next = '0;
    int rd_lat;

    always @(negedge clk) begin
        if (!rst) begin
            if (pq.size() > 0 && pq[0].due == cyc) begin
                pin_exp_t e;
                e = pq.pop_front();
                chk(!mem_ld_n, "R2 load", 64'(mem_ld_n), 64'(0));
                chk(mem_rw == !e.wr, "R2 rw", 64'(mem_rw), 64'(!e.wr));
                chk(mem_addr == e.addr, "R2 addr", 64'(mem_addr), 64'(e.addr));
                if (e.wr) chk(cyc - last_rd >= 2 + int'(cfg_two_gap), "R3 gap",
                              64'(cyc - last_rd - 1), 64'(1 + int'(cfg_two_gap)));
                else last_rd = cyc;
            end else begin
                chk(mem_ld_n, "R5 idle load", 64'(mem_ld_n), 64'(1));
            end
            if (wq.size() > 0 && wq[0].due == cyc) begin
                wr_exp_t w;
                w = wq.pop_front();
                chk(mem_d_rise == w.data[17:0], "R6 rise data", 64'(mem_d_rise), 64'(w.data[17:0]));
                chk(mem_d_fall == w.data[35:18], "R6 fall data", 64'(mem_d_fall), 64'(w.data[35:18]));
                chk({mem_be_fall, mem_be_rise} == w.be, "R6 enables",
                    64'({mem_be_fall, mem_be_rise}), 64'(w.be));
            end else begin
                chk({mem_be_fall, mem_be_rise} == 4'h0, "R6 stray enables",
                    64'({mem_be_fall, mem_be_rise}), 64'(0));
            end
            if (rsp_valid) begin
                if (rq.size() == 0) begin
                    chk(1'b0, "R9 extra response", 64'(rsp_tag), 64'(0));
                end else begin
                    rd_exp_t r;
                    r = rq.pop_front();
                    chk(cyc == r.due, "R7 latency", 64'(cyc), 64'(r.due));
                    chk(rsp_tag == r.tag, "R9 tag order", 64'(rsp_tag), 64'(r.tag));
                    chk(rsp_data == r.data, "R8 data", 64'(rsp_data), 64'(r.data));
                end
            end else if (rq.size() > 0 && rq[0].due <= cyc) begin
                chk(1'b0, "R7 missing response", 64'(cyc), 64'(rq[0].due));
                void'(rq.pop_front());
            end
        end
    end

    // ---------------- driver ----------------
    task automatic send(input bit wr, input logic [AW-1:0] a, input logic [35:0] d,
                        input logic [3:0] be, output int stalls);
        stalls = 0;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        req_tag   = wr ? '0 : tag_next;
        #1;
        while (!req_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        pq.push_back('{due: cyc + 1, wr: wr, addr: a});
        if (wr) begin
            wq.push_back('{due: cyc + 2, data: d, be: be});
            for (int ln = 0; ln < 2; ln++) begin
                if (be[ln])     mir[a][ln*9 +: 9] = d[ln*9 +: 9];
                if (be[2 + ln]) mir[a ^ AW'(1)][ln*9 +: 9] = d[18 + ln*9 +: 9];
            end
        end else begin
            rq.push_back('{due: cyc + rd_lat, tag: tag_next, data: {mir[a ^ AW'(1)], mir[a]}});
            tag_next = tag_next + TW'(1);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [35:0] pat(input int a, input int s);
        return {18'(a * 977 + s * 131 + 5), 18'(a * 613 + s * 29 + 11)};
    endfunction

    task automatic do_reset(input bit dll, input bit two);
        rst = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b1;
        cfg_dll_on = dll;
        cfg_two_gap = two;
        rd_lat = dll ? 5 : 4;
        pq.delete(); wq.delete(); rq.delete();
        for (int i = 0; i < NWORDS; i++) mir[i] = '0;
        last_rd = -100;
        repeat (3) @(negedge clk);
        chk(mem_ld_n, "R1 load in reset", 64'(mem_ld_n), 64'(1));
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(mem_ld_n, "R1 load after reset", 64'(mem_ld_n), 64'(1));
        chk(!rsp_valid, "R1 response after reset", 64'(rsp_valid), 64'(0));
        chk({mem_be_fall, mem_be_rise} == 4'h0, "R1 enables after reset",
            64'({mem_be_fall, mem_be_rise}), 64'(0));
        chk(req_ready, "R1 ready after reset", 64'(req_ready), 64'(1));
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R4 actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int st;
        for (int cfg = 0; cfg < 4; cfg++) begin
            bit dll;
            bit two;
            int g;
            dll = cfg[0];
            two = cfg[1];
            g = two ? 2 : 1;
            do_reset(dll, two);

            // R4: back-to-back writes over every address
            for (int a = 0; a < NWORDS; a++) begin
                send(1'b1, AW'(a), pat(a, cfg), 4'hF, st);
                chk(st == 0, "R4 write stream stall", 64'(st), 64'(0));
            end
            // R4, R8: back-to-back reads over every address
            for (int a = 0; a < NWORDS; a++) begin
                send(1'b0, AW'(a), '0, 4'h0, st);
                chk(st == 0, "R4 read stream stall", 64'(st), 64'(0));
            end
            idle(8);

            // R6: every enable pattern, each read back at once; R3 on the next write
            for (int m = 0; m < 16; m++) begin
                send(1'b1, AW'(m), pat(m, 40 + cfg), 4'(m), st);
                chk(st == (m == 0 ? 0 : g), "R3 stall after read", 64'(st), 64'(m == 0 ? 0 : g));
                send(1'b0, AW'(m), '0, 4'h0, st);
                chk(st == 0, "R4 read after write stall", 64'(st), 64'(0));
            end
            idle(8);

            // R3: read, k user idle cycles, then write
            for (int k = 0; k < 4; k++) begin
                int need;
                need = (g - k) > 0 ? (g - k) : 0;
                send(1'b0, AW'(k), '0, 4'h0, st);
                idle(k);
                send(1'b1, AW'(k + 8), pat(k, 90), 4'hF, st);
                chk(st == need, "R3 stall with idle", 64'(st), 64'(need));
                idle(2);
            end
            idle(10);
            chk(rq.size() == 0, "R9 all reads answered", 64'(rq.size()), 64'(0));
            chk(wq.size() == 0, "R6 all writes driven", 64'(wq.size()), 64'(0));
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule